// File: doc/BRIEF.md
# Two-Layer Colour Palette Lookup

This block holds two colour palettes, one for a background layer and one for a foreground layer, each made of 256 words of 32-bit ARGB8888 (alpha in bits 31:24, then red, green, blue). A pixel-side port takes an 8-bit or 4-bit index for either layer and returns the matching ARGB word one cycle later. A register-side bus port loads or inspects the palettes.

The bus port works in one of two access modes, chosen by `access_mode`. In streaming mode (`access_mode` = 0) each layer exposes a single data word. Every write stores the next entry at an internal write pointer, and every read returns the entry at an internal read pointer. Both pointers then step forward. In direct mode (`access_mode` = 1) the byte address picks the entry outright. A window whose selector bits [11:10] are 01 maps the background palette, one whose selector bits are 10 maps the foreground palette, and bits [9:2] give the entry index. Each layer has two clear controls, each acting on a 1-then-0 pulse. One zeroes the palette. The other returns the read pointer to entry 0. A palette clock-enable input stands in for clock and power gating.

Each palette bank runs a two-state machine. In IDLE it serves the bus and the pixel port. The transition IDLE→SWEEP fires on a completed clear pulse. In SWEEP a counter writes zero into one entry per cycle. The transition SWEEP→IDLE fires after the last entry has been written.

Top module: `palette_lut`

## Requirements
- R1: In streaming mode (`access_mode`=0), each bus write to a layer's data word (window offset 0) stores `bus_wdata` at that layer's write pointer and then increments the pointer. The pointer wraps from 255 to 0.
- R2: Bus accesses take effect only when the selector bits `bus_addr[11:10]` are 01 (background) or 10 (foreground) and `bus_addr[1:0]` is 00. In streaming mode, `bus_addr[9:2]` must also be 0. All other accesses change no entry and return no read data.
- R3: In direct mode (`access_mode`=1), a write stores into entry `bus_addr[9:2]` of the selected layer. A read returns that entry on `bus_rdata`, with `bus_rvalid` high, in the cycle after the request.
- R4: In streaming mode, a bus read returns the entry at the layer's read pointer one cycle later and then increments the pointer. The pointer wraps from 255 to 0.
- R5: When `rptr_clear[b]` falls after being high, layer b's read pointer returns to 0. The entries and the write pointer stay as they are.
- R6: When `mem_clear[b]` falls after being high, layer b enters SWEEP and zeroes all 256 entries over 256 cycles, and its write pointer returns to 0. While the sweep runs, that layer ignores bus accesses and stalls pixel requests aimed at it. The other layer keeps working.
- R7: A pixel request accepted with `pix_short`=0 (8-bit index) returns entry `pix_index` of layer `pix_layer` (0 = background, 1 = foreground) on `out_argb`, with `out_valid` high, in the next cycle.
- R8: A pixel request with `pix_short`=1 (4-bit index) uses only `pix_index[3:0]` and ignores the upper index bits.
- R9: A bus request to a valid window takes priority over the pixel port. In that cycle `pix_ready` is low, and no pixel result follows.
- R10: While `clk_en` is low, `pix_ready` is low and bus writes, bus reads and clear pulses have no effect.
- R11: After reset, `out_valid` and `bus_rvalid` are low, both banks are in IDLE, both pointers are 0, and `pix_ready` is high when `clk_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Palette clock enable; no access takes effect while low |
| access_mode | input | 1 | 0 = streaming through a data word, 1 = direct mapped |
| mem_clear | input | 2 | Per-layer palette clear; acts on the falling edge |
| rptr_clear | input | 2 | Per-layer read-pointer reset; acts on the falling edge |
| bus_wr | input | 1 | Bus write request |
| bus_rd | input | 1 | Bus read request |
| bus_addr | input | 12 | Bus byte address |
| bus_wdata | input | 32 | Bus write data, ARGB8888 |
| bus_rdata | output | 32 | Bus read data |
| bus_rvalid | output | 1 | Bus read data valid |
| pix_valid | input | 1 | Pixel lookup request |
| pix_ready | output | 1 | Pixel request accepted this cycle |
| pix_layer | input | 1 | 0 = background, 1 = foreground |
| pix_short | input | 1 | 1 = 4-bit index, 0 = 8-bit index |
| pix_index | input | 8 | Palette index |
| out_valid | output | 1 | Pixel result valid |
| out_argb | output | 32 | Pixel result, ARGB8888 |

## Verification
Every read result, whether from the pixel port or from the bus, is due exactly one clock edge after the request is accepted. The bench drives each request at a falling edge, lets one rising edge pass, and samples `out_valid`/`bus_rvalid` and the data at the following falling edge. `pix_ready` is combinational, so the bench checks it just after driving the request, in the same cycle. A clear pulse takes effect on the second rising edge after the pulse starts, and the sweep then needs 256 more edges. The bench checks the stall one cycle into the sweep and checks the zeroed contents only after waiting 260 cycles.

// File: rtl/palette_pkg.sv
package palette_pkg;

    // Window selector decoded from the top two address bits
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_BG   = 2'b01,
        SEL_FG   = 2'b10,
        SEL_RSVD = 2'b11
    } win_sel_e;

    // Per-bank controller states
    typedef enum logic {
        BK_IDLE  = 1'b0,
        BK_SWEEP = 1'b1
    } bank_state_e;

    localparam int NUM_LAYERS = 2;
    localparam int SHORT_W    = 4;

endpackage

// File: rtl/palette_decode.sv
module palette_decode
    import palette_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                  en,
    input  logic                  fifo_mode,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [IDX_W+3:0]      bus_addr,
    input  logic [NUM_LAYERS-1:0] busy,
    output logic [NUM_LAYERS-1:0] wr_hit,
    output logic [NUM_LAYERS-1:0] rd_hit,
    output logic                  bus_any,
    output logic [IDX_W-1:0]      idx
);

    localparam int SEL_LSB = IDX_W + 2;

    win_sel_e                sel;
    logic [NUM_LAYERS-1:0]   tgt;
    logic                    addr_ok;

    assign sel     = win_sel_e'(bus_addr[SEL_LSB+1:SEL_LSB]);
    assign idx     = bus_addr[SEL_LSB-1:2];
    assign addr_ok = (bus_addr[1:0] == 2'b00) && (!fifo_mode || (idx == '0));

    always_comb begin
        tgt = '0;
        unique case (sel)
            SEL_BG:   tgt[0] = 1'b1;
            SEL_FG:   tgt[1] = 1'b1;
            SEL_NONE,
            SEL_RSVD: tgt = '0;
        endcase
    end

    assign bus_any = en && (bus_wr || bus_rd) && addr_ok && (tgt != '0);

    for (genvar b = 0; b < NUM_LAYERS; b++) begin : g_hit
        assign wr_hit[b] = bus_any && bus_wr && tgt[b] && !busy[b];
        assign rd_hit[b] = bus_any && bus_rd && tgt[b] && !busy[b];
    end

endmodule

// File: rtl/palette_bank.sv
module palette_bank
    import palette_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_req,
    input  logic              rptr_clr,
    input  logic              fifo_mode,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              pix_rd,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic              busy,
    output logic [DATA_W-1:0] rdata
);

    localparam int              DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    bank_state_e        state_q, state_d;
    logic [IDX_W-1:0]   sweep_q, wptr_q, rptr_q;
    logic [DATA_W-1:0]  mem [DEPTH];

    logic               we;
    logic [IDX_W-1:0]   waddr, raddr;
    logic [DATA_W-1:0]  wd;
    logic               re;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE:  if (clr_req)          state_d = BK_SWEEP;
            BK_SWEEP: if (sweep_q == LAST)  state_d = BK_IDLE;
        endcase
    end

    // Outputs of the state machine: write port and read port selection
    always_comb begin
        we    = 1'b0;
        waddr = '0;
        wd    = '0;
        re    = 1'b0;
        raddr = pix_idx;
        unique case (state_q)
            BK_SWEEP: begin
                we    = 1'b1;
                waddr = sweep_q;
            end
            BK_IDLE: begin
                we    = bus_wr;
                waddr = fifo_mode ? wptr_q : bus_idx;
                wd    = bus_wdata;
                re    = bus_rd || pix_rd;
                raddr = bus_rd ? (fifo_mode ? rptr_q : bus_idx) : pix_idx;
            end
        endcase
    end

    assign busy = (state_q == BK_SWEEP);

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

    // Sweep counter and streaming pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            if (state_q == BK_IDLE && clr_req) begin
                sweep_q <= '0;
                wptr_q  <= '0;
            end else if (state_q == BK_SWEEP) begin
                sweep_q <= sweep_q + 1'b1;
            end else if (bus_wr && fifo_mode) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (rptr_clr)
                rptr_q <= '0;
            else if (state_q == BK_IDLE && bus_rd && fifo_mode)
                rptr_q <= rptr_q + 1'b1;
        end
    end

    // R1
    wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_IDLE && bus_wr && fifo_mode && !clr_req)
        |=> (wptr_q == IDX_W'($past(wptr_q) + 1'b1)));

    // R4
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_IDLE && bus_rd && fifo_mode && !rptr_clr)
        |=> (rptr_q == IDX_W'($past(rptr_q) + 1'b1)));

    // R5
    rptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rptr_clr |=> (rptr_q == '0));

    // R6
    sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sweep_q == '0 && wptr_q == '0));

    // R6
    sweep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sweep_q != LAST) |=> busy);

endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import palette_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              access_mode,
    input  logic [1:0]        mem_clear,
    input  logic [1:0]        rptr_clear,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [IDX_W+3:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic              pix_layer,
    input  logic              pix_short,
    input  logic [IDX_W-1:0]  pix_index,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_argb
);

    logic                  fifo_mode;
    logic [1:0]            clr_q, rpc_q, clr_fall, rpc_fall;
    logic [NUM_LAYERS-1:0] busy, wr_hit, rd_hit;
    logic                  bus_any, pix_fire;
    logic [IDX_W-1:0]      bus_idx, pix_idx;
    logic [DATA_W-1:0]     bank_rdata [NUM_LAYERS];
    logic                  out_sel_q, rd_sel_q;

    assign fifo_mode = (access_mode == 1'b0);

    // Falling-edge detection of the clear controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q <= '0;
            rpc_q <= '0;
        end else begin
            clr_q <= mem_clear;
            rpc_q <= rptr_clear;
        end
    end

    assign clr_fall = clr_q & ~mem_clear  & {2{clk_en}};
    assign rpc_fall = rpc_q & ~rptr_clear & {2{clk_en}};

    palette_decode #(.IDX_W(IDX_W)) u_decode (
        .en        (clk_en),
        .fifo_mode (fifo_mode),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .busy      (busy),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit),
        .bus_any   (bus_any),
        .idx       (bus_idx)
    );

    assign pix_ready = clk_en && !bus_any && !busy[pix_layer];
    assign pix_fire  = pix_valid && pix_ready;
    assign pix_idx   = pix_short ? IDX_W'(pix_index[SHORT_W-1:0]) : pix_index;

    for (genvar b = 0; b < NUM_LAYERS; b++) begin : g_bank
        palette_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_req   (clr_fall[b]),
            .rptr_clr  (rpc_fall[b]),
            .fifo_mode (fifo_mode),
            .bus_wr    (wr_hit[b]),
            .bus_rd    (rd_hit[b]),
            .bus_idx   (bus_idx),
            .bus_wdata (bus_wdata),
            .pix_rd    (pix_fire && (pix_layer == 1'(b))),
            .pix_idx   (pix_idx),
            .busy      (busy[b]),
            .rdata     (bank_rdata[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sel_q  <= 1'b0;
            bus_rvalid <= 1'b0;
            rd_sel_q   <= 1'b0;
        end else begin
            out_valid  <= pix_fire;
            if (pix_fire) out_sel_q <= pix_layer;
            bus_rvalid <= |rd_hit;
            if (|rd_hit) rd_sel_q <= rd_hit[1];
        end
    end

    assign out_argb  = bank_rdata[out_sel_q];
    assign bus_rdata = bank_rdata[rd_sel_q];

    // R9
    bus_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_any |-> !pix_ready);

    // R10
    gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (!pix_ready && rd_hit == '0 && wr_hit == '0));

    // R7
    pix_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_fire |=> out_valid);

    // R7
    pix_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid && pix_ready));

    // R3
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit != '0) |=> bus_rvalid);

    // R9
    one_reader_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rvalid && out_valid));

endmodule

// File: tb/palette_lut_bench.sv
`timescale 1ns/1ps
module palette_lut_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_en, access_mode;
    logic [1:0]  mem_clear, rptr_clear;
    logic        bus_wr, bus_rd;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rvalid;
    logic        pix_valid, pix_ready, pix_layer, pix_short;
    logic [7:0]  pix_index;
    logic        out_valid;
    logic [31:0] out_argb;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] mdl_bg [256];
    logic [31:0] mdl_fg [256];

    always #4 clk = ~clk;

    palette_lut u_palette_lut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .access_mode(access_mode),
        .mem_clear(mem_clear), .rptr_clear(rptr_clear),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_layer(pix_layer),
        .pix_short(pix_short), .pix_index(pix_index),
        .out_valid(out_valid), .out_argb(out_argb)
    );

    function automatic logic [31:0] bgv(int i);
        return 32'hFF00_0000 | (32'(i) * 32'h0001_0307);
    endfunction

    function automatic logic [31:0] fgv(int i);
        return (32'h8000_0000 ^ (32'(i) * 32'h0102_0408)) + 32'h11;
    endfunction

    function automatic logic [11:0] adr(logic [1:0] sel, int idx);
        return {sel, idx[7:0], 2'b00};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check({tag, " rvalid"}, 32'(bus_rvalid), 32'd1);
        check({tag, " rdata"}, bus_rdata, exp);
    endtask

    task automatic pix(logic layer, logic short_i, int idx, logic [31:0] exp, string tag);
        @(negedge clk);
        pix_valid = 1'b1; pix_layer = layer; pix_short = short_i; pix_index = idx[7:0];
        #1;
        if (pix_ready !== 1'b1) check({tag, " ready"}, 32'(pix_ready), 32'd1);
        @(negedge clk);
        pix_valid = 1'b0;
        check({tag, " valid"}, 32'(out_valid), 32'd1);
        check({tag, " argb"}, out_argb, exp);
    endtask

    task automatic pulse_clear(logic [1:0] v, bit rptr);
        @(negedge clk);
        if (rptr) rptr_clear = v; else mem_clear = v;
        @(negedge clk);
        rptr_clear = 2'b00; mem_clear = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; clk_en = 1'b1; access_mode = 1'b0;
        mem_clear = 2'b00; rptr_clear = 2'b00;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        pix_valid = 1'b0; pix_layer = 1'b0; pix_short = 1'b0; pix_index = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 out_valid", 32'(out_valid), 32'd0);
        check("R11 bus_rvalid", 32'(bus_rvalid), 32'd0);
        check("R11 pix_ready", 32'(pix_ready), 32'd1);

        // R6 clear both banks
        pulse_clear(2'b11, 1'b0);
        repeat (260) @(negedge clk);
        for (int i = 0; i < 256; i++) begin mdl_bg[i] = '0; mdl_fg[i] = '0; end
        pix(1'b0, 1'b0, 0, 32'h0, "R6 bg zero");
        pix(1'b1, 1'b0, 255, 32'h0, "R6 fg zero");

        // R1 streaming writes, with wrap past 255
        access_mode = 1'b0;
        for (int i = 0; i < 256; i++) begin
            bus_write(adr(2'b01, 0), bgv(i));
            mdl_bg[i] = bgv(i);
        end
        for (int k = 0; k < 2; k++) begin
            bus_write(adr(2'b01, 0), 32'hDEAD_0000 + 32'(k));
            mdl_bg[k] = 32'hDEAD_0000 + 32'(k);
        end
        // R2 streaming access at nonzero window offset is ignored
        bus_write(adr(2'b01, 5), 32'hBAD0_0005);
        // R4 streaming reads, full lap plus wrap
        for (int i = 0; i < 256; i++)
            bus_read(adr(2'b01, 0), mdl_bg[i], "R1 R4 stream read");
        bus_read(adr(2'b01, 0), mdl_bg[0], "R4 wrap0");
        bus_read(adr(2'b01, 0), mdl_bg[1], "R4 wrap1");
        // R5 read pointer reset
        pulse_clear(2'b01, 1'b1);
        bus_read(adr(2'b01, 0), mdl_bg[0], "R5 after rptr reset");
        bus_read(adr(2'b01, 0), mdl_bg[1], "R5 next");

        // R3 direct mode
        access_mode = 1'b1;
        for (int i = 0; i < 256; i++) begin
            bus_write(adr(2'b10, i), fgv(i));
            mdl_fg[i] = fgv(i);
        end
        for (int i = 0; i < 256; i += 17) begin
            bus_read(adr(2'b10, i), mdl_fg[i], "R3 fg direct");
            bus_read(adr(2'b01, i), mdl_bg[i], "R3 bg direct");
        end
        // R2 invalid windows and misaligned address
        bus_write(adr(2'b00, 3), 32'hBAD0_0001);
        bus_write(adr(2'b11, 3), 32'hBAD0_0002);
        bus_write(adr(2'b01, 3) | 12'h001, 32'hBAD0_0003);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = adr(2'b11, 3);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R2 no rvalid", 32'(bus_rvalid), 32'd0);
        bus_read(adr(2'b01, 3), mdl_bg[3], "R2 bg intact");
        bus_read(adr(2'b10, 3), mdl_fg[3], "R2 fg intact");

        // R7 full 8-bit sweep on both layers
        for (int i = 0; i < 256; i++) begin
            pix(1'b0, 1'b0, i, mdl_bg[i], "R7 bg");
            pix(1'b1, 1'b0, i, mdl_fg[i], "R7 fg");
        end
        // R8 4-bit indices ignore upper bits
        for (int i = 0; i < 256; i++) begin
            if (i[0]) pix(1'b1, 1'b1, i, mdl_fg[i % 16], "R8 fg short");
            else      pix(1'b0, 1'b1, i, mdl_bg[i % 16], "R8 bg short");
        end

        // R9 bus priority over pixel port
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = adr(2'b01, 9); bus_wdata = 32'hC0FF_EE09;
        pix_valid = 1'b1; pix_layer = 1'b0; pix_short = 1'b0; pix_index = 8'd9;
        #1 check("R9 stalled", 32'(pix_ready), 32'd0);
        @(negedge clk);
        bus_wr = 1'b0;
        mdl_bg[9] = 32'hC0FF_EE09;
        check("R9 no pixel result", 32'(out_valid), 32'd0);
        #1 check("R9 ready again", 32'(pix_ready), 32'd1);
        @(negedge clk);
        pix_valid = 1'b0;
        check("R9 result valid", 32'(out_valid), 32'd1);
        check("R9 result data", out_argb, mdl_bg[9]);

        // R10 clock enable low blocks everything
        @(negedge clk) clk_en = 1'b0;
        bus_write(adr(2'b01, 5), 32'h1234_5678);
        @(negedge clk);
        pix_valid = 1'b1; pix_layer = 1'b1;
        #1 check("R10 pix_ready low", 32'(pix_ready), 32'd0);
        @(negedge clk);
        pix_valid = 1'b0;
        check("R10 no pixel result", 32'(out_valid), 32'd0);
        pulse_clear(2'b11, 1'b0);
        @(negedge clk) clk_en = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(adr(2'b01, 5), mdl_bg[5], "R10 write ignored");
        pix(1'b1, 1'b0, 200, mdl_fg[200], "R10 clear ignored");

        // R6 clear foreground only, checking stall during sweep
        @(negedge clk) mem_clear = 2'b10;
        @(negedge clk) mem_clear = 2'b00;
        @(negedge clk);
        @(negedge clk);
        pix_valid = 1'b1; pix_layer = 1'b1;
        #1 check("R6 fg stalled in sweep", 32'(pix_ready), 32'd0);
        pix_layer = 1'b0;
        #1 check("R6 bg usable in sweep", 32'(pix_ready), 32'd1);
        pix_valid = 1'b0;
        repeat (260) @(negedge clk);
        for (int i = 0; i < 256; i++) mdl_fg[i] = '0;
        access_mode = 1'b0;
        bus_write(adr(2'b10, 0), 32'h5151_A0A0);
        mdl_fg[0] = 32'h5151_A0A0;
        pix(1'b1, 1'b0, 0, mdl_fg[0], "R6 wptr back to 0");
        for (int i = 1; i < 256; i += 31)
            pix(1'b1, 1'b0, i, 32'h0, "R6 fg zeroed");
        pix(1'b0, 1'b0, 100, mdl_bg[100], "R6 bg kept");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule